// File: doc/BRIEF.md
# Two-Wire Bus Clock-Low Timeout Monitor

This block sits passively beside a two-wire bus and watches the clock and data lines after a two-flop synchronizer. It finds START and STOP conditions and keeps a busy level. It raises a free level once the bus has stayed quiet for a minimum gap. While it watches, it applies three clock-low limits in parallel. The first limits each single low phase of the clock. The second caps the total low time across a whole message, which bounds how long the responding device may stretch the clock. The third caps the low time within each byte segment, which bounds how long the initiating device may stretch it.

When any limit is reached, the block emits a one-cycle timeout pulse with a cause code. On the next cycle it raises a release request. The surrounding logic uses this request to let go of both lines and to reset its protocol engine. The request holds until a STOP is seen or until the bus goes idle. All limits are parameters counted in system clock cycles, so the same block serves any clock rate.

Top module: `smb_tmo_mon`

## Requirements
- R1: After synchronous reset the outputs read busy 0, free 0, release 0, pulse 0 and cause 00.
- R2: A START (data falling while the clock is high) sets bus_busy 3 cycles after the input data edge. A STOP (data rising while the clock is high) clears bus_busy 3 cycles after the input data edge.
- R3: bus_free is high only while the bus is not busy. It rises exactly T_BUF_MIN cycles after bus_busy falls.
- R4: When the synchronized clock has been low for T_LOW_MAX cycles, tmo_pulse fires with cause 01. This is T_LOW_MAX+1 cycles after the input clock falls. Each low interval yields one such pulse however long it lasts, because the counter saturates and never wraps.
- R5: Clock-low cycles seen while busy are summed from the first START to the STOP. Reaching T_SLV_MAX gives a pulse with cause 10. The sum clears on STOP, so two short messages never add up.
- R6: A repeated START (a START while busy) leaves the message-wide sum unchanged.
- R7: Clock-low cycles seen while busy are also summed per byte segment. A segment ends at the ninth clock rising edge. Reaching T_MST_MAX within one segment gives a pulse with cause 11.
- R8: A repeated START begins a new byte segment, clearing the per-segment sum and the edge count.
- R9: tmo_cause reads 00 whenever tmo_pulse is low. When several limits are reached in one cycle, cause 01 wins over 10, and 10 wins over 11.
- R10: release_lines rises the cycle after a pulse and holds until a STOP or idle. While it is high, the two budget limits produce no pulse, but the clock-low limit still does.
- R11: If both lines stay high for T_HIGH_IDLE cycles, bus_busy and release_lines clear. This happens T_HIGH_IDLE+3 cycles after the input clock rises.
- R12: A synchronous reset in the middle of a message returns the block to the idle state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| bus_busy | output | 1 | A message is in progress |
| bus_free | output | 1 | Bus idle for at least the minimum gap |
| tmo_pulse | output | 1 | One-cycle timeout event |
| tmo_cause | output | 2 | 00 none, 01 clock low, 10 message budget, 11 segment budget |
| release_lines | output | 1 | Request to free both lines and reset protocol logic |

## Verification
Each input edge needs two synchronizer cycles before the monitor can see it. A register stage follows, so busy and release respond 3 cycles after the input edge. A clock-low pulse comes T_LOW_MAX+1 cycles after the clock input falls. The free level follows the fall of busy by exactly T_BUF_MIN cycles. The bench stamps every drive and every pulse with a cycle count taken on the falling clock edge. It compares those stamps against these latencies, and it samples the levels on the exact cycle before and after each expected change.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

  typedef enum logic [1:0] {
    TMO_NONE    = 2'b00,
    TMO_CLK_LOW = 2'b01,
    TMO_SLAVE   = 2'b10,
    TMO_MASTER  = 2'b11
  } tmo_cause_e;

  // saturating increment: never passes cap
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] cap);
    return (v >= cap) ? cap : v + 32'd1;
  endfunction

  // fixed priority: clock low, then message budget, then segment budget
  function automatic tmo_cause_e pick_cause(input logic lo, input logic sl, input logic ms);
    if (lo)      return TMO_CLK_LOW;
    else if (sl) return TMO_SLAVE;
    else if (ms) return TMO_MASTER;
    else         return TMO_NONE;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, synced, dly;
  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] sh;
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], raw[g]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= raw[g];
      end
    end
    assign synced[g] = sh[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) dly <= 2'b11;
    else     dly <= synced;
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~dly[0];
  assign start_det = synced[0] & dly[0] & dly[1] & ~synced[1];
  assign stop_det  = synced[0] & dly[0] & ~dly[1] & synced[1];
endmodule

// File: rtl/smb_budget.sv
module smb_budget
  import smb_tmo_pkg::*;
#(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= CW'(sat_step(32'(cnt), 32'(LIMIT)));
  end

  // fires on the cycle that brings the sum to LIMIT; saturation blocks repeats
  assign hit = en && !clr && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/smb_bus_state.sv
module smb_bus_state
  import smb_tmo_pkg::*;
#(
  parameter int T_BUF_MIN   = 5,
  parameter int T_HIGH_IDLE = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  input  logic start_det,
  input  logic stop_det,
  output logic busy,
  output logic free,
  output logic idle_seen
);
  localparam int HW = $clog2(T_HIGH_IDLE + 1);
  localparam int FW = $clog2(T_BUF_MIN + 1);
  logic [HW-1:0] hi_cnt;
  logic [FW-1:0] free_cnt;

  always_ff @(posedge clk) begin
    if (rst || !(scl_s && sda_s)) hi_cnt <= '0;
    else hi_cnt <= HW'(sat_step(32'(hi_cnt), 32'(T_HIGH_IDLE)));
  end

  assign idle_seen = scl_s && sda_s && (hi_cnt == HW'(T_HIGH_IDLE));

  always_ff @(posedge clk) begin
    if (rst)                        busy <= 1'b0;
    else if (start_det)             busy <= 1'b1;
    else if (stop_det || idle_seen) busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || busy) free_cnt <= '0;
    else free_cnt <= FW'(sat_step(32'(free_cnt), 32'(T_BUF_MIN)));
  end

  assign free = !busy && (free_cnt == FW'(T_BUF_MIN));
endmodule

// File: rtl/smb_tmo_mon.sv
module smb_tmo_mon
  import smb_tmo_pkg::*;
#(
  parameter int T_LOW_MAX   = 25000,
  parameter int T_SLV_MAX   = 25000,
  parameter int T_MST_MAX   = 10000,
  parameter int T_BUF_MIN   = 5,
  parameter int T_HIGH_IDLE = 50,
  parameter int SEG_EDGES   = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       bus_busy,
  output logic       bus_free,
  output logic       tmo_pulse,
  output logic [1:0] tmo_cause,
  output logic       release_lines
);
  localparam int BW = $clog2(SEG_EDGES + 1);

  logic scl_s, sda_s, scl_rise, start_det, stop_det, idle_seen;
  logic first_start, seg_end, slv_clr, mst_clr, low_busy;
  logic lo_hit, slv_hit, mst_hit;
  logic [BW-1:0] edge_cnt;
  tmo_cause_e cause;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_bus_state #(.T_BUF_MIN(T_BUF_MIN), .T_HIGH_IDLE(T_HIGH_IDLE)) u_state (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .busy(bus_busy), .free(bus_free), .idle_seen(idle_seen)
  );

  assign first_start = start_det && !bus_busy;
  assign seg_end     = scl_rise && bus_busy && (edge_cnt == BW'(SEG_EDGES - 1));
  assign slv_clr     = first_start || stop_det || idle_seen;
  assign mst_clr     = start_det || stop_det || idle_seen || seg_end;
  assign low_busy    = bus_busy && !scl_s;

  always_ff @(posedge clk) begin
    if (rst || start_det || stop_det || idle_seen) edge_cnt <= '0;
    else if (scl_rise && bus_busy)
      edge_cnt <= seg_end ? '0 : edge_cnt + BW'(1);
  end

  smb_budget #(.LIMIT(T_LOW_MAX)) u_low (
    .clk(clk), .rst(rst), .clr(scl_s), .en(!scl_s), .hit(lo_hit)
  );
  smb_budget #(.LIMIT(T_SLV_MAX)) u_slv (
    .clk(clk), .rst(rst), .clr(slv_clr), .en(low_busy), .hit(slv_hit)
  );
  smb_budget #(.LIMIT(T_MST_MAX)) u_mst (
    .clk(clk), .rst(rst), .clr(mst_clr), .en(low_busy), .hit(mst_hit)
  );

  assign cause     = pick_cause(lo_hit, slv_hit && !release_lines, mst_hit && !release_lines);
  assign tmo_cause = cause;
  assign tmo_pulse = (cause != TMO_NONE);

  always_ff @(posedge clk) begin
    if (rst || stop_det || idle_seen) release_lines <= 1'b0;
    else if (tmo_pulse)               release_lines <= 1'b1;
  end
endmodule

// File: rtl/smb_tmo_chk.sv
module smb_tmo_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_busy,
  input logic       bus_free,
  input logic       tmo_pulse,
  input logic [1:0] tmo_cause,
  input logic       release_lines,
  input logic       start_det,
  input logic       stop_det,
  input logic       idle_seen,
  input logic       scl_s
);
  assert_free_excl_R3: assert property (@(posedge clk) disable iff (rst)
    bus_free |-> !bus_busy);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> bus_busy);

  assert_stop_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> !bus_busy);

  assert_pulse_low_R4: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> !scl_s);

  assert_one_low_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (tmo_pulse && tmo_cause == 2'b01) |=> !(tmo_pulse && tmo_cause == 2'b01));

  assert_release_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (release_lines && !stop_det && !idle_seen) |=> release_lines);

  assert_release_src_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(release_lines) |-> $past(tmo_pulse));

  assert_budget_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (release_lines && tmo_pulse) |-> (tmo_cause == 2'b01));

  assert_idle_clear_R11: assert property (@(posedge clk) disable iff (rst)
    idle_seen |=> (!bus_busy && !release_lines));

  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> (!bus_busy && !release_lines));
endmodule

bind smb_tmo_mon smb_tmo_chk u_chk (
  .clk(clk), .rst(rst), .bus_busy(bus_busy), .bus_free(bus_free),
  .tmo_pulse(tmo_pulse), .tmo_cause(tmo_cause), .release_lines(release_lines),
  .start_det(start_det), .stop_det(stop_det), .idle_seen(idle_seen), .scl_s(scl_s)
);

// File: tb/sim_smb_tmo_mon.sv
module sim_smb_tmo_mon;
  localparam int CLK_PERIOD = 10;
  localparam int L    = 40;
  localparam int S    = 150;
  localparam int M    = 60;
  localparam int BUF  = 10;
  localparam int IDLE = 50;
  localparam int HI   = 6;

  typedef struct packed {
    logic [7:0] nclk;
    logic [7:0] lo;
    logic [3:0] npulse;
    logic [1:0] cause;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd18, 8'd5,   4'd0, 2'd0},
    '{8'd18, 8'd5,   4'd0, 2'd0},
    '{8'd36, 8'd5,   4'd1, 2'd2},
    '{8'd9,  8'd7,   4'd1, 2'd3},
    '{8'd1,  8'd65,  4'd1, 2'd1},
    '{8'd1,  8'd200, 4'd1, 2'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic bus_busy, bus_free, tmo_pulse, release_lines;
  logic [1:0] tmo_cause;

  int nchk = 0, nfail = 0;
  int cyc = 0, npulse = 0, last_pulse_cyc = 0, bad_cause = 0;
  logic [1:0] last_cause = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smb_tmo_mon #(.T_LOW_MAX(L), .T_SLV_MAX(S), .T_MST_MAX(M), .T_BUF_MIN(BUF),
                .T_HIGH_IDLE(IDLE), .SEG_EDGES(9)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .bus_busy(bus_busy), .bus_free(bus_free), .tmo_pulse(tmo_pulse),
    .tmo_cause(tmo_cause), .release_lines(release_lines)
  );

  always @(negedge clk) begin
    if (!rst && tmo_pulse) begin
      npulse++;
      last_cause = tmo_cause;
      last_pulse_cyc = cyc;
    end
    if (!rst && !tmo_pulse && tmo_cause != 2'b00) bad_cause++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string req_of(input logic [1:0] c);
    case (c)
      2'd1:    return "R4";
      2'd2:    return "R5";
      2'd3:    return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic clocks(input int n, input int lo);
    for (int i = 0; i < n; i++) begin
      scl = 1'b0; wait_cyc(lo);
      scl = 1'b1; wait_cyc(HI);
    end
  endtask

  task automatic do_stop();
    wait_cyc(HI);
    sda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int p0, c, s;
    wait_cyc(3);
    // R1 reset state
    chk("R1 busy", bus_busy, 0);
    chk("R1 free", bus_free, 0);
    chk("R1 release", release_lines, 0);
    chk("R1 pulse", tmo_pulse, 0);
    chk("R1 cause", tmo_cause, 0);
    rst = 1'b0;
    wait_cyc(BUF + 5);

    // vector table
    for (int v = 0; v < 6; v++) begin
      p0 = npulse;
      sda = 1'b0; wait_cyc(HI);
      clocks(VECS[v].nclk, VECS[v].lo);
      chk("R10 release before stop", release_lines, (VECS[v].npulse != 0) ? 1 : 0);
      do_stop();
      wait_cyc(BUF + 8);
      chk(req_of(VECS[v].cause), npulse - p0, VECS[v].npulse);
      if (VECS[v].npulse != 0) chk("R9 cause code", last_cause, VECS[v].cause);
      chk("R10 release after stop", release_lines, 0);
      chk("R3 free after gap", bus_free, 1);
    end

    // R2 start latency
    sda = 1'b0;
    wait_cyc(2); chk("R2 busy early", bus_busy, 0);
    wait_cyc(1); chk("R2 busy set", bus_busy, 1);
    wait_cyc(HI);
    // R4 clock-low latency
    p0 = npulse;
    scl = 1'b0; c = cyc;
    wait_cyc(100);
    chk("R4 pulse count", npulse - p0, 1);
    chk("R4 pulse latency", last_pulse_cyc - c, L + 1);
    chk("R10 release set", release_lines, 1);
    scl = 1'b1; wait_cyc(HI);
    sda = 1'b1; s = cyc;
    wait_cyc(2); chk("R2 busy before stop", bus_busy, 1);
    wait_cyc(1); chk("R2 busy cleared", bus_busy, 0);
    chk("R10 release cleared by stop", release_lines, 0);
    wait_cyc(BUF - 1); chk("R3 free early", bus_free, 0);
    wait_cyc(1); chk("R3 free rise", bus_free, 1);
    chk("R3 free timing base", cyc - s, BUF + 3);
    wait_cyc(5);

    // R6 R8 repeated START: segments stay short, message sum grows
    p0 = npulse;
    sda = 1'b0; wait_cyc(HI);
    for (int k = 0; k < 5; k++) begin
      clocks(7, 5);
      scl = 1'b0; wait_cyc(5);
      sda = 1'b1; wait_cyc(1);
      scl = 1'b1; wait_cyc(HI);
      sda = 1'b0; wait_cyc(HI);
    end
    chk("R8 no segment timeout", npulse - p0, 1);
    chk("R6 message budget cause", last_cause, 2);
    do_stop();
    wait_cyc(BUF + 8);

    // R11 idle release
    sda = 1'b0; wait_cyc(HI);
    scl = 1'b0; wait_cyc(60);
    chk("R11 release before idle", release_lines, 1);
    sda = 1'b1; wait_cyc(2);
    scl = 1'b1; c = cyc;
    wait_cyc(2 + IDLE); chk("R11 release held", release_lines, 1);
    wait_cyc(1);
    chk("R11 release cleared", release_lines, 0);
    chk("R11 busy cleared", bus_busy, 0);
    chk("R11 timing base", cyc - c, IDLE + 3);
    wait_cyc(BUF + 5);

    // R12 reset mid-message
    sda = 1'b0; wait_cyc(HI);
    scl = 1'b0; wait_cyc(60);
    rst = 1'b1; scl = 1'b1; sda = 1'b1;
    wait_cyc(1);
    chk("R12 busy", bus_busy, 0);
    chk("R12 release", release_lines, 0);
    chk("R12 pulse", tmo_pulse, 0);
    rst = 1'b0;
    wait_cyc(5);

    chk("R9 cause idle when no pulse", bad_cause, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule